// File: doc/BRIEF.md
# Timing-State Flush Sequencer

This block sits behind the decoder of cache-maintenance commands and turns each command into clear controls for the microarchitectural state that can leak timing information. It controls four structures. Two are cleared in constant time: the in-core branch predictor and the prefetcher state. Two are cleared one entry per cycle through an index/write-enable port: the tagged branch target buffer and the outer-cache replacement (LRU) bits. A command names an operation class (whole hierarchy, instruction cache, data cache or address range) and carries the funct7 specifier, and one bit of funct7 is the timing-channel flag.

Each accepted command either traps or starts every selected flash clear and scan at the same time. The block reports completion with a one-cycle done pulse and does not accept another command until that pulse has gone. Three configuration inputs are sampled at acceptance. One makes commands without the flag clear timing state anyway. One lets address-range commands clear the address-linked structures. One makes flagged commands trap. A build parameter can make flagged commands always trap.

Top module: `tsflush_seq`

## Requirements
- R1: A whole-hierarchy command (cmd_op=0) with the flag in effect pulses both flash clears and scans the full target buffer and the full LRU array.
- R2: An instruction-cache command (cmd_op=1) with the flag in effect pulses the branch-predictor flash clear and scans the target buffer. It issues no prefetcher clear and no LRU write.
- R3: A data-cache command (cmd_op=2) with the flag in effect pulses the prefetcher flash clear and scans the LRU array. It issues no branch-predictor clear and no target-buffer write.
- R4: The timing-channel flag is funct7 bit TC_BIT (default 6). The other funct7 bits have no effect on the result.
- R5: When cfg_force_tc is low, a command without the flag clears nothing, does not trap, and raises rsp_done in the cycle after acceptance.
- R6: When cfg_force_tc is high, a command without the flag clears the same structures as the same class with the flag set. It never traps, whatever cfg_tc_trap says.
- R7: An address-range command (cmd_op=3) with the flag in effect scans both the target buffer and the LRU array when cfg_range_clear is high. When cfg_range_clear is low it clears nothing.
- R8: A command with the flag set traps when cfg_tc_trap is high or the ALWAYS_TRAP parameter is set. A trapped command gives rsp_done and rsp_trap together in the cycle after acceptance, with no clear or write activity.
- R9: Each flash clear is a single-cycle pulse in the cycle after acceptance.
- R10: Each selected scan asserts its write enable for exactly DEPTH consecutive cycles, starting in the cycle after acceptance, with the index counting 0 to DEPTH-1.
- R11: rsp_done is a single-cycle pulse in the cycle after the last write of the longest selected scan. cmd_ready is low from the cycle after acceptance through the done cycle and high again in the following cycle.
- R12: After reset cmd_ready is high and all clear, write and response outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Sequencer idle and able to take a command |
| cmd_op | input | 2 | Class: 0 whole, 1 instruction cache, 2 data cache, 3 address range |
| cmd_funct7 | input | 7 | Specifier field carrying the timing-channel flag |
| cfg_force_tc | input | 1 | Treat every command as flagged (conservative mode) |
| cfg_range_clear | input | 1 | Let address-range commands clear address-linked state |
| cfg_tc_trap | input | 1 | Trap flagged commands |
| bp_flash_clr | output | 1 | Branch-predictor flash clear pulse |
| pf_flash_clr | output | 1 | Prefetcher flash clear pulse |
| btb_we | output | 1 | Target-buffer clear write enable |
| btb_idx | output | BTB_IW | Target-buffer entry index |
| lru_we | output | 1 | Replacement-bit clear write enable |
| lru_idx | output | LRU_IW | Replacement-bit entry index |
| rsp_done | output | 1 | Command complete pulse |
| rsp_trap | output | 1 | Command trapped, valid with rsp_done |

## Verification
The command is accepted on the clock edge where cmd_valid and cmd_ready are both high. Flash pulses and the first scan write are due one cycle later. The last write of a DEPTH-entry scan is due DEPTH cycles after acceptance, and done comes one cycle after the longest selected scan, or one cycle after acceptance when the command traps or selects no scan. The bench numbers the cycles from the accept edge and samples every output on the falling edge of each cycle. It checks the cycle of every pulse, the number of writes, the index order, the done cycle, and cmd_ready on the cycle after done against values derived from the class, the flag and the depths.

// File: rtl/tsf_pkg.sv
package tsf_pkg;

  typedef enum logic [1:0] {
    OP_WHOLE = 2'd0,
    OP_ICACHE = 2'd1,
    OP_DCACHE = 2'd2,
    OP_RANGE = 2'd3
  } tsf_op_e;

  typedef struct packed {
    logic bp;
    logic pf;
    logic btb;
    logic lru;
  } tsf_sel_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN = 2'd1,
    ST_DONE = 2'd2
  } tsf_state_e;

endpackage

// File: rtl/tsf_decode.sv
module tsf_decode
  import tsf_pkg::*;
#(
  parameter int TC_BIT = 6,
  parameter bit ALWAYS_TRAP = 1'b0
) (
  input  logic [1:0] op,
  input  logic [6:0] funct7,
  input  logic       force_tc,
  input  logic       range_clear,
  input  logic       tc_trap,
  output tsf_sel_t   sel,
  output logic       trap
);

  logic tc_raw;
  logic tc_eff;
  tsf_op_e op_e;

  assign tc_raw = funct7[TC_BIT];
  assign tc_eff = tc_raw | force_tc;
  assign op_e = tsf_op_e'(op);
  assign trap = tc_raw & (ALWAYS_TRAP | tc_trap);

  always_comb begin
    sel = '0;
    if (tc_eff) begin
      unique case (op_e)
        OP_WHOLE: begin
          sel.bp = 1'b1;
          sel.pf = 1'b1;
          sel.btb = 1'b1;
          sel.lru = 1'b1;
        end
        OP_ICACHE: begin
          sel.bp = 1'b1;
          sel.btb = 1'b1;
        end
        OP_DCACHE: begin
          sel.pf = 1'b1;
          sel.lru = 1'b1;
        end
        OP_RANGE: begin
          sel.btb = range_clear;
          sel.lru = range_clear;
        end
        default: sel = '0;
      endcase
    end
  end

endmodule

// File: rtl/tsf_scan_unit.sv
module tsf_scan_unit #(
  parameter int DEPTH = 64,
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output logic          we,
  output logic [IW-1:0] idx,
  output logic          last
);

  localparam logic [IW-1:0] LAST_IDX = IW'(DEPTH - 1);

  logic          act_q, act_d;
  logic [IW-1:0] idx_q, idx_d;

  assign we = act_q;
  assign idx = idx_q;
  assign last = act_q && (idx_q == LAST_IDX);

  always_comb begin
    act_d = act_q;
    idx_d = idx_q;
    if (start) begin
      act_d = 1'b1;
      idx_d = '0;
    end else if (act_q) begin
      if (idx_q == LAST_IDX) begin
        act_d = 1'b0;
      end else begin
        idx_d = idx_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      idx_q <= '0;
    end else begin
      act_q <= act_d;
      idx_q <= idx_d;
    end
  end

endmodule

// File: rtl/tsflush_seq.sv
module tsflush_seq
  import tsf_pkg::*;
#(
  parameter int BTB_DEPTH = 64,
  parameter int LRU_DEPTH = 256,
  parameter int TC_BIT = 6,
  parameter bit ALWAYS_TRAP = 1'b0,
  localparam int BTB_IW = (BTB_DEPTH > 1) ? $clog2(BTB_DEPTH) : 1,
  localparam int LRU_IW = (LRU_DEPTH > 1) ? $clog2(LRU_DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [1:0]        cmd_op,
  input  logic [6:0]        cmd_funct7,
  input  logic              cfg_force_tc,
  input  logic              cfg_range_clear,
  input  logic              cfg_tc_trap,
  output logic              bp_flash_clr,
  output logic              pf_flash_clr,
  output logic              btb_we,
  output logic [BTB_IW-1:0] btb_idx,
  output logic              lru_we,
  output logic [LRU_IW-1:0] lru_idx,
  output logic              rsp_done,
  output logic              rsp_trap
);

  tsf_state_e state_q, state_d;
  tsf_sel_t   sel;
  logic       trap;
  logic       accept;
  logic       go;
  logic       bp_q, bp_d, pf_q, pf_d;
  logic       trap_q, trap_d;
  logic       btb_last, lru_last;
  logic       scans_end;

  tsf_decode #(
    .TC_BIT(TC_BIT),
    .ALWAYS_TRAP(ALWAYS_TRAP)
  ) dec_i (
    .op(cmd_op),
    .funct7(cmd_funct7),
    .force_tc(cfg_force_tc),
    .range_clear(cfg_range_clear),
    .tc_trap(cfg_tc_trap),
    .sel(sel),
    .trap(trap)
  );

  assign cmd_ready = (state_q == ST_IDLE);
  assign accept = cmd_valid & cmd_ready;
  assign go = accept & ~trap;

  tsf_scan_unit #(.DEPTH(BTB_DEPTH)) btb_scan_i (
    .clk(clk),
    .rst_n(rst_n),
    .start(go & sel.btb),
    .we(btb_we),
    .idx(btb_idx),
    .last(btb_last)
  );

  tsf_scan_unit #(.DEPTH(LRU_DEPTH)) lru_scan_i (
    .clk(clk),
    .rst_n(rst_n),
    .start(go & sel.lru),
    .we(lru_we),
    .idx(lru_idx),
    .last(lru_last)
  );

  assign scans_end = (~btb_we | btb_last) & (~lru_we | lru_last);

  always_comb begin
    state_d = state_q;
    trap_d = trap_q;
    bp_d = go & sel.bp;
    pf_d = go & sel.pf;
    unique case (state_q)
      ST_IDLE: begin
        if (accept) begin
          trap_d = trap;
          if (trap || !(sel.btb || sel.lru)) begin
            state_d = ST_DONE;
          end else begin
            state_d = ST_RUN;
          end
        end
      end
      ST_RUN: begin
        if (scans_end) begin
          state_d = ST_DONE;
        end
      end
      ST_DONE: begin
        state_d = ST_IDLE;
        trap_d = 1'b0;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      trap_q <= 1'b0;
      bp_q <= 1'b0;
      pf_q <= 1'b0;
    end else begin
      state_q <= state_d;
      trap_q <= trap_d;
      bp_q <= bp_d;
      pf_q <= pf_d;
    end
  end

  assign bp_flash_clr = bp_q;
  assign pf_flash_clr = pf_q;
  assign rsp_done = (state_q == ST_DONE);
  assign rsp_trap = rsp_done & trap_q;

endmodule

// File: rtl/tsflush_seq_chk.sv
module tsflush_seq_chk #(
  parameter int BTB_DEPTH = 64,
  parameter int LRU_DEPTH = 256,
  localparam int BTB_IW = (BTB_DEPTH > 1) ? $clog2(BTB_DEPTH) : 1,
  localparam int LRU_IW = (LRU_DEPTH > 1) ? $clog2(LRU_DEPTH) : 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_ready,
  input logic              bp_flash_clr,
  input logic              pf_flash_clr,
  input logic              btb_we,
  input logic [BTB_IW-1:0] btb_idx,
  input logic              lru_we,
  input logic [LRU_IW-1:0] lru_idx,
  input logic              rsp_done,
  input logic              rsp_trap
);

  AST_BP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    bp_flash_clr |=> !bp_flash_clr); // R9
  AST_PF_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    pf_flash_clr |=> !pf_flash_clr); // R9
  AST_TRAP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_trap |-> (rsp_done && !btb_we && !lru_we && !bp_flash_clr && !pf_flash_clr)); // R8
  AST_BTB_IDX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (btb_we && $past(btb_we)) |-> (btb_idx == $past(btb_idx) + 1'b1)); // R10
  AST_LRU_IDX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (lru_we && $past(lru_we)) |-> (lru_idx == $past(lru_idx) + 1'b1)); // R10
  AST_BTB_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    btb_we |-> (int'(btb_idx) < BTB_DEPTH)); // R10
  AST_LRU_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    lru_we |-> (int'(lru_idx) < LRU_DEPTH)); // R10
  AST_DONE_AFTER_SCANS: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |-> (!btb_we && !lru_we && !cmd_ready)); // R11
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> (!rsp_done && cmd_ready)); // R11
  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (btb_we || lru_we || bp_flash_clr || pf_flash_clr) |-> !cmd_ready); // R11

endmodule

bind tsflush_seq tsflush_seq_chk #(
  .BTB_DEPTH(BTB_DEPTH),
  .LRU_DEPTH(LRU_DEPTH)
) chk_i (
  .clk(clk),
  .rst_n(rst_n),
  .cmd_ready(cmd_ready),
  .bp_flash_clr(bp_flash_clr),
  .pf_flash_clr(pf_flash_clr),
  .btb_we(btb_we),
  .btb_idx(btb_idx),
  .lru_we(lru_we),
  .lru_idx(lru_idx),
  .rsp_done(rsp_done),
  .rsp_trap(rsp_trap)
);

// File: tb/tsflush_seq_tb_top.sv
module tsflush_seq_tb_top;

  localparam int DB = 8;
  localparam int DL = 20;
  localparam int BIW = $clog2(DB);
  localparam int LIW = $clog2(DL);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic cmd_ready;
  logic [1:0] cmd_op = 2'd0;
  logic [6:0] cmd_funct7 = 7'd0;
  logic cfg_force_tc = 1'b0;
  logic cfg_range_clear = 1'b0;
  logic cfg_tc_trap = 1'b0;
  logic bp_flash_clr, pf_flash_clr, btb_we, lru_we, rsp_done, rsp_trap;
  logic [BIW-1:0] btb_idx;
  logic [LIW-1:0] lru_idx;

  int n_cmp = 0;
  int n_bad = 0;
  bit ended = 1'b0;

  always #4 clk = ~clk;

  tsflush_seq #(.BTB_DEPTH(DB), .LRU_DEPTH(DL)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_funct7(cmd_funct7),
    .cfg_force_tc(cfg_force_tc), .cfg_range_clear(cfg_range_clear),
    .cfg_tc_trap(cfg_tc_trap),
    .bp_flash_clr(bp_flash_clr), .pf_flash_clr(pf_flash_clr),
    .btb_we(btb_we), .btb_idx(btb_idx),
    .lru_we(lru_we), .lru_idx(lru_idx),
    .rsp_done(rsp_done), .rsp_trap(rsp_trap)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Issue one command, observe cycles after the accept edge, compare with expectation.
  task automatic run(input string req, input logic [1:0] op, input logic [6:0] f7,
                     input bit e_bp, input bit e_pf, input bit e_btb, input bit e_lru,
                     input bit e_trap);
    int bp_n = 0, pf_n = 0, bp_c = 0, pf_c = 0;
    int btb_n = 0, lru_n = 0, btb_bad = 0, lru_bad = 0;
    int btb_end = 0, lru_end = 0, done_c = 0, trap_v = 0, rdy_bad = 0, rdy_after;
    int exp_done, scan_max;
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_op = op;
    cmd_funct7 = f7;
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    for (int c = 1; c < 200; c++) begin
      if (bp_flash_clr) begin bp_n++; bp_c = c; end
      if (pf_flash_clr) begin pf_n++; pf_c = c; end
      if (btb_we) begin
        if (int'(btb_idx) != btb_n) btb_bad++;
        btb_n++; btb_end = c;
      end
      if (lru_we) begin
        if (int'(lru_idx) != lru_n) lru_bad++;
        lru_n++; lru_end = c;
      end
      if (cmd_ready) rdy_bad++;
      if (rsp_done) begin
        done_c = c;
        trap_v = int'(rsp_trap);
        break;
      end
      @(negedge clk);
    end
    @(negedge clk);
    rdy_after = int'(cmd_ready);
    scan_max = 0;
    if (e_btb && DB > scan_max) scan_max = DB;
    if (e_lru && DL > scan_max) scan_max = DL;
    exp_done = e_trap ? 1 : scan_max + 1;
    chk(req, "bp pulses", bp_n, int'(e_bp));
    if (e_bp) chk({req, " R9"}, "bp pulse cycle", bp_c, 1);
    chk(req, "pf pulses", pf_n, int'(e_pf));
    if (e_pf) chk({req, " R9"}, "pf pulse cycle", pf_c, 1);
    chk(req, "btb writes", btb_n, e_btb ? DB : 0);
    chk(req, "lru writes", lru_n, e_lru ? DL : 0);
    if (e_btb) begin
      chk({req, " R10"}, "btb index order errors", btb_bad, 0);
      chk({req, " R10"}, "btb last write cycle", btb_end, DB);
    end
    if (e_lru) begin
      chk({req, " R10"}, "lru index order errors", lru_bad, 0);
      chk({req, " R10"}, "lru last write cycle", lru_end, DL);
    end
    chk({req, " R11"}, "done cycle", done_c, exp_done);
    chk({req, " R8"}, "trap flag", trap_v, int'(e_trap));
    chk({req, " R11"}, "ready low while busy", rdy_bad, 0);
    chk({req, " R11"}, "ready after done", rdy_after, 1);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R12", "ready", int'(cmd_ready), 1);
    chk("R12", "outputs", int'({bp_flash_clr, pf_flash_clr, btb_we, lru_we, rsp_done, rsp_trap}), 0);
  endtask

  task automatic t_whole();
    run("R1", 2'd0, 7'h40, 1, 1, 1, 1, 0);
  endtask

  task automatic t_icache();
    run("R2", 2'd1, 7'h40, 1, 0, 1, 0, 0);
  endtask

  task automatic t_dcache();
    run("R3", 2'd2, 7'h40, 0, 1, 0, 1, 0);
  endtask

  task automatic t_flag_bit();
    run("R4 other bits set, flag set", 2'd1, 7'h7F, 1, 0, 1, 0, 0);
    run("R4 other bits set, flag clear", 2'd0, 7'h3F, 0, 0, 0, 0, 0);
  endtask

  task automatic t_no_flag();
    run("R5", 2'd0, 7'h00, 0, 0, 0, 0, 0);
    run("R5 dcache", 2'd2, 7'h00, 0, 0, 0, 0, 0);
  endtask

  task automatic t_force();
    cfg_force_tc = 1'b1;
    cfg_tc_trap = 1'b1;
    run("R6 dcache forced", 2'd2, 7'h00, 0, 1, 0, 1, 0);
    run("R6 whole forced", 2'd0, 7'h00, 1, 1, 1, 1, 0);
    cfg_force_tc = 1'b0;
    cfg_tc_trap = 1'b0;
  endtask

  task automatic t_range();
    cfg_range_clear = 1'b0;
    run("R7 range disabled", 2'd3, 7'h40, 0, 0, 0, 0, 0);
    cfg_range_clear = 1'b1;
    run("R7 range enabled", 2'd3, 7'h40, 0, 0, 1, 1, 0);
    run("R7 range no flag", 2'd3, 7'h00, 0, 0, 0, 0, 0);
    cfg_range_clear = 1'b0;
  endtask

  task automatic t_trap();
    cfg_tc_trap = 1'b1;
    run("R8 whole trapped", 2'd0, 7'h40, 0, 0, 0, 0, 1);
    run("R8 unflagged not trapped", 2'd1, 7'h00, 0, 0, 0, 0, 0);
    cfg_tc_trap = 1'b0;
    run("R8 trap cleared", 2'd1, 7'h40, 1, 0, 1, 0, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_whole();
    t_icache();
    t_dcache();
    t_flag_bit();
    t_no_flag();
    t_force();
    t_range();
    t_trap();
    if (!ended) begin
      ended = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!ended) begin
      ended = 1'b1;
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule